// File: doc/BRIEF.md
# Serial Gamepad Reader with Reread Verification

This block drives a parallel-load, serial-out gamepad shift register from the host side. For each pass it raises a shared latch line to reload the pad, then lowers it and walks the pad through its 8-bit button report. One bit is sampled at the end of every clock-low phase. Between samples the selected port's clock is pulsed high. Each port has two data lines, a main line and an expansion line. A button counts as pressed when either line is 1.

A stray extra clock edge during a pass makes the pad drop a bit. The rest of the report then shifts up and a 1 fills in at the bottom. To guard against this, the reader does not trust a single pass. It repeats passes on the requested port until two passes in a row give the same byte, and only then reports that byte. Each request covers one port; the two ports are never read in a combined pass. A programmable mismatch limit stops a pad whose data changes on every pass from holding the reader forever. When the limit is hit, the reader reports an error instead of a result.

Top module: `pad_verify_reader`

## Requirements
- R1: Every pass starts with `latch_o` high for exactly LATCH_CYC clocks, and no pad clock is high while `latch_o` is high.
- R2: The first bit sampled after the latch falls lands in bit 7 of the report and the eighth in bit 0. In button terms: A=7, B=6, Select=5, Start=4, Up=3, Down=2, Left=1, Right=0.
- R3: The sampled bit is the OR of the selected port's two data lines. Bit 0 is the main line and bit 1 is the expansion line.
- R4: A pass ends after exactly eight samples, detected by a 0x01 marker preloaded into the shift register leaving bit 7. A pass therefore emits exactly seven clock pulses.
- R5: `valid_o` pulses for one clock only when two consecutive passes agree, and `buttons_o` then holds that byte. A clean read completes 2·P clocks after the start is accepted, where P = LATCH_CYC + 8·CLK_LO_CYC + 7·CLK_HI_CYC + 1.
- R6: After a mismatch the reader runs another pass. It succeeds when the latest two passes agree: 3·P clocks when the first pass is corrupt, 4·P when the second is.
- R7: After MAX_RETRY mismatches in one request, `error_o` pulses for one clock instead of `valid_o`, at (MAX_RETRY+1)·P clocks, and `buttons_o` keeps its previous value.
- R8: Only the clock of the port named by `port_sel_i` at start toggles, and only that port's data lines are sampled.
- R9: `start_i` is ignored while `busy_o` is high.
- R10: Out of reset, `latch_o`, both pad clocks, `busy_o`, `valid_o` and `error_o` are low and `buttons_o` is zero.
- R11: Each pad clock pulse stays high for exactly CLK_HI_CYC clocks, and each bit period has a low phase of CLK_LO_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a verified read (taken when idle) |
| port_sel_i | input | 1 | Port to read: 0 or 1 |
| latch_o | output | 1 | Shared latch (reload) line to both pads |
| pad_clk_o | output | 2 | Per-port shift clock |
| p0_data_i | input | 2 | Port 0 data: bit 0 main, bit 1 expansion |
| p1_data_i | input | 2 | Port 1 data: bit 0 main, bit 1 expansion |
| busy_o | output | 1 | A request is in progress |
| valid_o | output | 1 | One-clock pulse: verified report on `buttons_o` |
| error_o | output | 1 | One-clock pulse: mismatch limit reached |
| buttons_o | output | 8 | Last verified report |

## Verification
Every result is due at a whole number of passes after the start is accepted: 2·P for a clean read, 3·P or 4·P after one corrupt pass, and (MAX_RETRY+1)·P on abort. The driver stores that count with each expected item. The monitor samples on the falling edge and compares the clock count since acceptance against it exactly. It therefore catches both early and late results. A result that appears with no expected item queued is also counted as a failure.

// File: rtl/padrd_pkg.sv
package padrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_LOW,
    ST_HIGH,
    ST_CHECK
  } rd_state_e;
endpackage

// File: rtl/pad_phase_timer.sv
// Down counter that times latch and clock phases; zero_o marks the last cycle.
module pad_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = load_val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pad_ring_shifter.sv
// Report register preloaded with a single marker bit; last_o says the next
// shift pushes the marker out, i.e. completes the report.
module pad_ring_shifter #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [RW-1:0] report_o,
  output logic          last_o
);
  localparam logic [RW-1:0] MARKER = RW'(1);
  logic [RW-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (init_i)       sr_d = MARKER;
    else if (shift_i) sr_d = {sr_q[RW-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign report_o = sr_q;
  assign last_o   = sr_q[RW-1];
endmodule

// File: rtl/pad_match_tracker.sv
// Keeps the previous pass and the mismatch count of the current request.
module pad_match_tracker #(
  parameter int RW        = 8,
  parameter int MAX_RETRY = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          eval_i,
  input  logic [RW-1:0] report_i,
  output logic          accept_o,
  output logic          abort_o
);
  localparam int CW = $clog2(MAX_RETRY + 1);
  localparam logic [CW-1:0] LAST_MISS = CW'(MAX_RETRY - 1);

  logic [RW-1:0] prev_q, prev_d;
  logic          have_q, have_d;
  logic [CW-1:0] miss_q, miss_d;
  logic          same;

  assign same     = (report_i == prev_q);
  assign accept_o = eval_i && have_q && same;
  assign abort_o  = eval_i && have_q && !same && (miss_q == LAST_MISS);

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    miss_d = miss_q;
    if (clear_i) begin
      have_d = 1'b0;
      miss_d = '0;
    end else if (eval_i && !accept_o) begin
      prev_d = report_i;
      have_d = 1'b1;
      if (have_q) miss_d = miss_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
      miss_q <= '0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/pad_verify_reader.sv
module pad_verify_reader
  import padrd_pkg::*;
#(
  parameter int LATCH_CYC  = 12,
  parameter int CLK_LO_CYC = 6,
  parameter int CLK_HI_CYC = 6,
  parameter int MAX_RETRY  = 8,
  parameter int REPORT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                port_sel_i,
  output logic                latch_o,
  output logic [1:0]          pad_clk_o,
  input  logic [1:0]          p0_data_i,
  input  logic [1:0]          p1_data_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic                error_o,
  output logic [REPORT_W-1:0] buttons_o
);
  localparam int MAX_A  = (LATCH_CYC > CLK_LO_CYC) ? LATCH_CYC : CLK_LO_CYC;
  localparam int MAX_PH = (MAX_A > CLK_HI_CYC) ? MAX_A : CLK_HI_CYC;
  localparam int TW     = $clog2(MAX_PH + 1);
  localparam logic [TW-1:0] LATCH_LD = TW'(LATCH_CYC - 1);
  localparam logic [TW-1:0] LO_LD    = TW'(CLK_LO_CYC - 1);
  localparam logic [TW-1:0] HI_LD    = TW'(CLK_HI_CYC - 1);

  rd_state_e             state_q, state_d;
  logic                  port_q, port_d;
  logic [REPORT_W-1:0]   buttons_q, buttons_d;
  logic                  valid_q, valid_d;
  logic                  error_q, error_d;

  logic                  t_load, t_zero;
  logic [TW-1:0]         t_val;
  logic                  sh_init, sh_shift, sh_last, bit_in;
  logic [REPORT_W-1:0]   report;
  logic                  trk_clear, trk_eval, accept, abort;

  assign bit_in = port_q ? (|p1_data_i) : (|p0_data_i);

  pad_phase_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(t_load), .load_val_i(t_val), .zero_o(t_zero)
  );

  pad_ring_shifter #(.RW(REPORT_W)) shifter_i (
    .clk(clk), .rst_n(rst_n), .init_i(sh_init), .shift_i(sh_shift),
    .bit_i(bit_in), .report_o(report), .last_o(sh_last)
  );

  pad_match_tracker #(.RW(REPORT_W), .MAX_RETRY(MAX_RETRY)) tracker_i (
    .clk(clk), .rst_n(rst_n), .clear_i(trk_clear), .eval_i(trk_eval),
    .report_i(report), .accept_o(accept), .abort_o(abort)
  );

  // Next-state process
  always_comb begin
    state_d   = state_q;
    port_d    = port_q;
    buttons_d = buttons_q;
    valid_d   = 1'b0;
    error_d   = 1'b0;
    t_load    = 1'b0;
    t_val     = LATCH_LD;
    sh_init   = 1'b0;
    sh_shift  = 1'b0;
    trk_clear = 1'b0;
    trk_eval  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_LATCH;
        port_d    = port_sel_i;
        t_load    = 1'b1;
        t_val     = LATCH_LD;
        sh_init   = 1'b1;
        trk_clear = 1'b1;
      end
      ST_LATCH: if (t_zero) begin
        state_d = ST_LOW;
        t_load  = 1'b1;
        t_val   = LO_LD;
      end
      ST_LOW: if (t_zero) begin
        sh_shift = 1'b1;
        if (sh_last) begin
          state_d = ST_CHECK;
        end else begin
          state_d = ST_HIGH;
          t_load  = 1'b1;
          t_val   = HI_LD;
        end
      end
      ST_HIGH: if (t_zero) begin
        state_d = ST_LOW;
        t_load  = 1'b1;
        t_val   = LO_LD;
      end
      ST_CHECK: begin
        trk_eval = 1'b1;
        if (accept) begin
          state_d   = ST_IDLE;
          valid_d   = 1'b1;
          buttons_d = report;
        end else if (abort) begin
          state_d = ST_IDLE;
          error_d = 1'b1;
        end else begin
          state_d = ST_LATCH;
          t_load  = 1'b1;
          t_val   = LATCH_LD;
          sh_init = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      port_q    <= 1'b0;
      buttons_q <= '0;
      valid_q   <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      port_q    <= port_d;
      buttons_q <= buttons_d;
      valid_q   <= valid_d;
      error_q   <= error_d;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pclk
    assign pad_clk_o[p] = (state_q == ST_HIGH) && (port_q == 1'(p));
  end

  assign latch_o   = (state_q == ST_LATCH);
  assign busy_o    = (state_q != ST_IDLE);
  assign valid_o   = valid_q;
  assign error_o   = error_q;
  assign buttons_o = buttons_q;
endmodule

// File: rtl/padrd_checker.sv
module padrd_checker #(
  parameter int LATCH_CYC  = 12,
  parameter int CLK_HI_CYC = 6,
  parameter int REPORT_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                latch_o,
  input logic [1:0]          pad_clk_o,
  input logic                busy_o,
  input logic                valid_o,
  input logic                error_o,
  input logic [REPORT_W-1:0] buttons_o
);
  logic [15:0] lat_run, clk_run;
  logic        any_clk;
  assign any_clk = |pad_clk_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_run <= '0;
      clk_run <= '0;
    end else begin
      lat_run <= latch_o ? lat_run + 1'b1 : '0;
      clk_run <= any_clk ? clk_run + 1'b1 : '0;
    end
  end

  assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> (pad_clk_o == 2'b00));
  assert_latch_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_o) |-> (lat_run == 16'(LATCH_CYC)));
  assert_clk_high_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_clk) |-> (clk_run == 16'(CLK_HI_CYC)));
  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_clk_o));
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!busy_o && !error_o));
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> $stable(buttons_o));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!latch_o && !any_clk));
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !valid_o && !error_o) |=> (busy_o || valid_o || error_o));
endmodule

bind pad_verify_reader padrd_checker #(
  .LATCH_CYC(LATCH_CYC), .CLK_HI_CYC(CLK_HI_CYC), .REPORT_W(REPORT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .latch_o(latch_o),
  .pad_clk_o(pad_clk_o), .busy_o(busy_o), .valid_o(valid_o),
  .error_o(error_o), .buttons_o(buttons_o)
);

// File: tb/pad_verify_reader_tb.sv
module pad_verify_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L = 3, LO = 2, HI = 2, MR = 4;
  localparam int P = L + 8 * LO + 7 * HI + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, port_sel_i = 1'b0;
  logic latch_o, busy_o, valid_o, error_o;
  logic [1:0] pad_clk_o, p0_data_i, p1_data_i;
  logic [7:0] buttons_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pad_verify_reader #(.LATCH_CYC(L), .CLK_LO_CYC(LO), .CLK_HI_CYC(HI),
                      .MAX_RETRY(MR), .REPORT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .port_sel_i(port_sel_i),
    .latch_o(latch_o), .pad_clk_o(pad_clk_o), .p0_data_i(p0_data_i),
    .p1_data_i(p1_data_i), .busy_o(busy_o), .valid_o(valid_o),
    .error_o(error_o), .buttons_o(buttons_o)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pad model: reloads while latched, shifts in 1s on each clock rise.
  logic [7:0] btn [2];
  logic [7:0] sh [2];
  logic       route [2];            // 0: main line, 1: expansion line
  logic       pclk_d [2];
  logic       lat_d = 1'b0;
  int         rises [2];
  int         pass_no = 0;
  int         inj_pass = 0, inj_at = 0;
  bit         flip_all = 1'b0;
  int         flip_once = 0;

  always_comb begin
    p0_data_i = route[0] ? {sh[0][7], 1'b0} : {1'b0, sh[0][7]};
    p1_data_i = route[1] ? {sh[1][7], 1'b0} : {1'b0, sh[1][7]};
  end

  always @(posedge clk) begin
    lat_d <= latch_o;
    if (latch_o && !lat_d) begin
      pass_no <= pass_no + 1;
      if (pass_no >= 1 && (flip_all || flip_once > 0)) begin
        btn[0] <= ~btn[0];
        btn[1] <= ~btn[1];
        if (flip_once > 0) flip_once <= flip_once - 1;
      end
    end
    for (int p = 0; p < 2; p++) begin
      pclk_d[p] <= pad_clk_o[p];
      if (latch_o) begin
        sh[p] <= btn[p];
      end else if (pad_clk_o[p] && !pclk_d[p]) begin
        rises[p] <= rises[p] + 1;
        if (pass_no == inj_pass && rises[p] % 7 == inj_at)
          sh[p] <= {sh[p][5:0], 2'b11};   // extra stray pulse
        else
          sh[p] <= {sh[p][6:0], 1'b1};
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit is_err; logic [7:0] val; int due; int start_cyc; } item_t;
  item_t sb[$];

  // Monitor
  always @(negedge clk) begin
    if (rst_n && (valid_o || error_o)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected result", int'(buttons_o), 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(error_o == it.is_err, it.is_err ? "R7 kind" : "R5 kind", int'(error_o), int'(it.is_err));
        check(buttons_o == it.val, "R2 R5 R7 value", int'(buttons_o), int'(it.val));
        check(cyc - it.start_cyc == it.due, "R5 R6 R7 latency", cyc - it.start_cyc, it.due);
      end
    end
  end

  task automatic do_read(input logic port, input logic [7:0] exp_val,
                         input bit is_err, input int due, input bit poke);
    item_t it;
    pass_no = 0;
    it.is_err = is_err; it.val = exp_val; it.due = due; it.start_cyc = cyc + 1;
    sb.push_back(it);
    port_sel_i = port;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      port_sel_i = ~port;            // R9: start while busy is ignored
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    btn[0] = 8'hA6; btn[1] = 8'h3C;
    sh[0] = 8'h00;  sh[1] = 8'h00;
    route[0] = 1'b0; route[1] = 1'b0;
    pclk_d[0] = 1'b0; pclk_d[1] = 1'b0;
    rises[0] = 0; rises[1] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!latch_o && pad_clk_o == 2'b00, "R10 pins", int'({latch_o, pad_clk_o}), 0);
    check(!busy_o && !valid_o && !error_o, "R10 flags", int'({busy_o, valid_o, error_o}), 0);
    check(buttons_o == 8'h00, "R10 buttons", int'(buttons_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R5: clean read port 0, 14 clock rises over two passes
    rises[0] = 0;
    do_read(1'b0, 8'hA6, 1'b0, 2 * P, 1'b0);
    check(rises[0] == 14, "R4 pulses", rises[0], 14);

    // R8: port 1 read leaves port 0 clock idle
    rises[0] = 0; rises[1] = 0;
    do_read(1'b1, 8'h3C, 1'b0, 2 * P, 1'b0);
    check(rises[0] == 0, "R8 idle port", rises[0], 0);
    check(rises[1] == 14, "R8 R4 active port", rises[1], 14);

    // R3: data on expansion line only
    route[0] = 1'b1; btn[0] = 8'h81;
    do_read(1'b0, 8'h81, 1'b0, 2 * P, 1'b0);
    route[0] = 1'b0;

    // R2: patterns at edges of the report
    btn[0] = 8'h00; do_read(1'b0, 8'h00, 1'b0, 2 * P, 1'b0);
    btn[0] = 8'hFF; do_read(1'b0, 8'hFF, 1'b0, 2 * P, 1'b0);

    // R6: stray pulse in first pass -> three passes, clean value
    btn[0] = 8'h52; rises[0] = 0; inj_pass = 1; inj_at = 3;
    do_read(1'b0, 8'h52, 1'b0, 3 * P, 1'b0);
    // R6: stray pulse in second pass -> four passes
    rises[0] = 0; inj_pass = 2; inj_at = 1;
    do_read(1'b0, 8'h52, 1'b0, 4 * P, 1'b0);
    inj_pass = 0;

    // R6: buttons change after the first pass
    btn[1] = 8'h0F; flip_once = 1;
    do_read(1'b1, 8'hF0, 1'b0, 3 * P, 1'b0);

    // R7: data changes every pass -> abort, buttons_o keeps 8'hF0
    flip_all = 1'b1;
    do_read(1'b1, 8'hF0, 1'b1, (MR + 1) * P, 1'b0);
    flip_all = 1'b0;
    check(!busy_o, "R7 idle after abort", int'(busy_o), 0);

    // R9: start pulse while busy ignored
    btn[0] = 8'h24;
    do_read(1'b0, 8'h24, 1'b0, 2 * P, 1'b1);
    check(!busy_o && buttons_o == 8'h24, "R9 no extra read", int'(buttons_o), 8'h24);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule